// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the 8-bit status word of a processor core and decides, every clock, how it changes. Arithmetic results arrive from the core's adder/subtractor as a result word and a vector of per-bit carry (or borrow) outputs. An operand-size select picks byte, word or long. From these the block derives half-carry, negative, zero, overflow and carry. A per-flag enable lets each instruction say which flags it may touch.

Software can overwrite the whole word, or combine it with an 8-bit immediate by AND, OR or XOR. The current value is always visible on an output for store operations. A single-cycle exception-entry pulse sets the interrupt-mask bit, which also drives a dedicated output. The size-dependent flag taps come from a parameterised bank of lanes, one per operand size. Each lane is twice as wide as the one before it.

Top module: `status_flag_reg`

## Requirements
- R1: After reset the status word reads 0x80: mask bit set, all other bits 0, and `irq_masked` high.
- R2: Bit layout, high to low: bit 7 interrupt mask, bit 6 user bit A, bit 5 half-carry, bit 4 user bit B, bit 3 negative, bit 2 zero, bit 1 overflow, bit 0 carry; `irq_masked` always equals bit 7.
- R3: The half-carry is the carry/borrow out of bit 3 for size code 0 (byte), bit 11 for code 1 (word), bit 27 for code 2 (long); code 3 behaves as long.
- R4: The negative flag takes result bit 7, 15 or 31 for byte, word or long.
- R5: The zero flag is set exactly when the result, cut to the selected size, is all zeros; higher result bits are ignored.
- R6: The carry flag is the carry/borrow out of the top bit of the selected size; overflow is the XOR of the carry/borrow out of the top bit and of the bit below it.
- R7: With `arith_upd` high, only flags whose `flag_en` bit is set change (bit 4 half-carry, 3 negative, 2 zero, 1 overflow, 0 carry); with `arith_upd` low and no other request the word holds.
- R8: `sw_op` codes: 0 none, 1 load immediate, 2 AND, 3 OR, 4 XOR with `sw_imm`; the new value appears on the clock edge that samples the request. Codes 5 to 7 act as none.
- R9: Arithmetic updates never change bit 7, bit 6 or bit 4.
- R10: `exc_entry` sets bit 7 on the next edge; if a software write arrives in the same cycle, the other bits come from the software write and bit 7 is still 1.
- R11: When a software write and an arithmetic update arrive together, the software write alone determines the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_entry | input | 1 | Exception-entry pulse, sets the mask bit |
| sw_op | input | 3 | Software operation code |
| sw_imm | input | 8 | Software immediate / load value |
| arith_upd | input | 1 | Arithmetic flag update request |
| flag_en | input | 5 | Per-flag update enables {H,N,Z,V,C} |
| op_size | input | 2 | Operand size code (0 byte, 1 word, 2/3 long) |
| alu_result | input | 32 | Adder/subtractor result word |
| alu_cout | input | 32 | Carry or borrow out of each result bit |
| ccr_q | output | 8 | Current status word |
| irq_masked | output | 1 | Interrupt mask bit |

## Verification
The bench builds the block with its default parameters: an 8-bit base lane, three sizes and a nibble half-carry gap. The flag taps therefore fall on bits 3, 11 and 27, with top bits 7, 15 and 31. This makes every size reachable, including the reserved size code that falls back to long. The result words it drives keep garbage above the selected size, which tests that zero and negative ignore those bits. Collisions between exception entry, software writes and arithmetic updates are driven in the same cycle to exercise the priority order.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   localparam int REG_W  = 8;
   localparam int POS_I  = 7;
   localparam int POS_UA = 6;
   localparam int POS_H  = 5;
   localparam int POS_UB = 4;
   localparam int POS_N  = 3;
   localparam int POS_Z  = 2;
   localparam int POS_V  = 1;
   localparam int POS_C  = 0;

   typedef enum logic [2:0] {
      SW_NONE = 3'd0,
      SW_LOAD = 3'd1,
      SW_AND  = 3'd2,
      SW_OR   = 3'd3,
      SW_XOR  = 3'd4
   } sw_op_e;

   typedef struct packed {
      logic h;
      logic n;
      logic z;
      logic v;
      logic c;
   } arith_flags_t;
endpackage

// File: rtl/sfr_size_lane.sv
module sfr_size_lane
   import sfr_pkg::*;
#(
   parameter int LANE_W   = 8,
   parameter int HALF_TAP = 3
) (
   input  logic [LANE_W-1:0] res,
   input  logic [LANE_W-1:0] cout,
   output arith_flags_t      flags
);
   if (LANE_W < 2) begin : g_bad_w
      $error("sfr_size_lane: LANE_W must be at least 2");
   end
   if (HALF_TAP < 0 || HALF_TAP >= LANE_W - 1) begin : g_bad_tap
      $error("sfr_size_lane: HALF_TAP outside lane");
   end

   localparam int TOP = LANE_W - 1;

   always_comb begin
      flags.h = cout[HALF_TAP];
      flags.n = res[TOP];
      flags.z = ~|res;
      flags.c = cout[TOP];
      flags.v = cout[TOP] ^ cout[TOP-1];
   end
endmodule

// File: rtl/sfr_flag_gen.sv
module sfr_flag_gen
   import sfr_pkg::*;
#(
   parameter int BASE_W    = 8,
   parameter int NUM_SIZES = 3,
   parameter int HALF_GAP  = 4,
   localparam int DATA_W   = BASE_W << (NUM_SIZES - 1),
   localparam int SIZE_W   = $clog2(NUM_SIZES)
) (
   input  logic [SIZE_W-1:0] op_size,
   input  logic [DATA_W-1:0] alu_result,
   input  logic [DATA_W-1:0] alu_cout,
   output arith_flags_t      flags
);
   if (NUM_SIZES < 2) begin : g_bad_sizes
      $error("sfr_flag_gen: NUM_SIZES must be at least 2");
   end
   if (HALF_GAP < 1 || BASE_W < HALF_GAP + 2) begin : g_bad_gap
      $error("sfr_flag_gen: HALF_GAP does not fit BASE_W");
   end

   arith_flags_t lane_flags [NUM_SIZES];

   for (genvar i = 0; i < NUM_SIZES; i++) begin : g_lane
      localparam int LW = BASE_W << i;
      sfr_size_lane #(
         .LANE_W   (LW),
         .HALF_TAP (LW - HALF_GAP - 1)
      ) u_lane (
         .res   (alu_result[LW-1:0]),
         .cout  (alu_cout[LW-1:0]),
         .flags (lane_flags[i])
      );
   end

   int eff_idx;

   always_comb begin
      eff_idx = int'(op_size);
      if (eff_idx >= NUM_SIZES) eff_idx = NUM_SIZES - 1;
      flags = '0;
      for (int i = 0; i < NUM_SIZES; i++) begin
         if (eff_idx == i) flags = lane_flags[i];
      end
   end
endmodule

// File: rtl/sfr_sw_alu.sv
module sfr_sw_alu
   import sfr_pkg::*;
(
   input  logic [2:0]       op,
   input  logic [REG_W-1:0] cur,
   input  logic [REG_W-1:0] imm,
   output logic             wr,
   output logic [REG_W-1:0] val
);
   sw_op_e op_e;

   always_comb begin
      op_e = sw_op_e'(op);
      wr   = 1'b1;
      val  = cur;
      case (op_e)
         SW_LOAD: val = imm;
         SW_AND:  val = cur & imm;
         SW_OR:   val = cur | imm;
         SW_XOR:  val = cur ^ imm;
         default: wr  = 1'b0;
      endcase
   end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
   import sfr_pkg::*;
#(
   parameter int          BASE_W    = 8,
   parameter int          NUM_SIZES = 3,
   parameter int          HALF_GAP  = 4,
   parameter logic [6:0]  RESET_LOW = 7'h00,
   localparam int         DATA_W    = BASE_W << (NUM_SIZES - 1),
   localparam int         SIZE_W    = $clog2(NUM_SIZES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_entry,
   input  logic [2:0]        sw_op,
   input  logic [REG_W-1:0]  sw_imm,
   input  logic              arith_upd,
   input  logic [4:0]        flag_en,
   input  logic [SIZE_W-1:0] op_size,
   input  logic [DATA_W-1:0] alu_result,
   input  logic [DATA_W-1:0] alu_cout,
   output logic [REG_W-1:0]  ccr_q,
   output logic              irq_masked
);
   localparam logic [REG_W-1:0] RESET_VAL = {1'b1, RESET_LOW};

   arith_flags_t      calc_flags;
   arith_flags_t      en_f;
   logic              sw_wr;
   logic [REG_W-1:0]  sw_val;
   logic [REG_W-1:0]  ccr_d;

   sfr_flag_gen #(
      .BASE_W    (BASE_W),
      .NUM_SIZES (NUM_SIZES),
      .HALF_GAP  (HALF_GAP)
   ) u_flags (
      .op_size    (op_size),
      .alu_result (alu_result),
      .alu_cout   (alu_cout),
      .flags      (calc_flags)
   );

   sfr_sw_alu u_sw (
      .op  (sw_op),
      .cur (ccr_q),
      .imm (sw_imm),
      .wr  (sw_wr),
      .val (sw_val)
   );

   always_comb begin
      en_f  = arith_flags_t'(flag_en);
      ccr_d = ccr_q;
      if (sw_wr) begin
         ccr_d = sw_val;
      end else if (arith_upd) begin
         if (en_f.h) ccr_d[POS_H] = calc_flags.h;
         if (en_f.n) ccr_d[POS_N] = calc_flags.n;
         if (en_f.z) ccr_d[POS_Z] = calc_flags.z;
         if (en_f.v) ccr_d[POS_V] = calc_flags.v;
         if (en_f.c) ccr_d[POS_C] = calc_flags.c;
      end
      if (exc_entry) ccr_d[POS_I] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ccr_q <= RESET_VAL;
      else        ccr_q <= ccr_d;
   end

   assign irq_masked = ccr_q[POS_I];

   assert_exc_sets_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_entry |=> ccr_q[POS_I]);

   assert_arith_keeps_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (arith_upd && !sw_wr && !exc_entry) |=>
         ($stable(ccr_q[POS_I]) && $stable(ccr_q[POS_UA]) && $stable(ccr_q[POS_UB])));

   assert_disabled_half_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (arith_upd && sw_op == 3'd0 && !flag_en[4]) |=> $stable(ccr_q[POS_H]));

   assert_load_takes_imm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_op == 3'd1 && !exc_entry) |=> ccr_q == $past(sw_imm));

   assert_sw_beats_arith_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_op == 3'd1 && arith_upd && exc_entry) |=>
         (ccr_q == ($past(sw_imm) | 8'h80)));

   assert_mask_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ccr_q[POS_I]) |-> $rose(irq_masked));
endmodule

// File: tb/status_flag_reg_test.sv
module status_flag_reg_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        exc_entry;
   logic [2:0]  sw_op;
   logic [7:0]  sw_imm;
   logic        arith_upd;
   logic [4:0]  flag_en;
   logic [1:0]  op_size;
   logic [31:0] alu_result;
   logic [31:0] alu_cout;
   logic [7:0]  ccr_q;
   logic        irq_masked;

   always #2 clk = ~clk;

   status_flag_reg uut (
      .clk(clk), .rst_n(rst_n), .exc_entry(exc_entry), .sw_op(sw_op),
      .sw_imm(sw_imm), .arith_upd(arith_upd), .flag_en(flag_en),
      .op_size(op_size), .alu_result(alu_result), .alu_cout(alu_cout),
      .ccr_q(ccr_q), .irq_masked(irq_masked)
   );

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t      sbq[$];
   int         total = 0;
   int         bad = 0;
   logic [7:0] m;
   bit         done = 0;

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per edge after the driver pushed it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(ccr_q, it.exp, it.tag);
            check({7'd0, irq_masked}, {7'd0, it.exp[7]}, "R2 mask output");
         end
      end
   end

   // adder / subtractor model producing the result and per-bit carry chain
   function automatic void chain(input logic [31:0] a, input logic [31:0] b, input bit sub,
                                 output logic [31:0] r, output logic [31:0] co);
      logic cy = 1'b0;
      for (int k = 0; k < 32; k++) begin
         r[k] = a[k] ^ b[k] ^ cy;
         if (sub) cy = (~a[k] & b[k]) | (~(a[k] ^ b[k]) & cy);
         else     cy = (a[k] & b[k]) | (cy & (a[k] ^ b[k]));
         co[k] = cy;
      end
   endfunction

   task automatic drive(input logic [2:0] op, input logic [7:0] imm, input bit upd,
                        input logic [4:0] en, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] b, input bit sub, input bit exc, input string tag);
      logic [31:0] r, co;
      int          w;
      logic [63:0] mk, hm, aa, bb;
      logic        h, n, z, v, c, sa, sb, sr;
      logic [7:0]  nx;
      item_t       it;
      @(negedge clk);
      chain(a, b, sub, r, co);
      exc_entry = exc; sw_op = op; sw_imm = imm; arith_upd = upd; flag_en = en;
      op_size = sz; alu_result = r; alu_cout = co;
      w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      mk = (64'd1 << w) - 64'd1;
      hm = (64'd1 << (w - 4)) - 64'd1;
      aa = {32'd0, a};
      bb = {32'd0, b};
      if (sub) begin
         c = (aa & mk) < (bb & mk);
         h = (aa & hm) < (bb & hm);
      end else begin
         c = (((aa & mk) + (bb & mk)) >> w) & 64'd1;
         h = (((aa & hm) + (bb & hm)) >> (w - 4)) & 64'd1;
      end
      z  = (({32'd0, r} & mk) == 64'd0);
      n  = r[w-1];
      sa = a[w-1]; sb = b[w-1]; sr = r[w-1];
      v  = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
      nx = m;
      case (op)
         3'd1: nx = imm;
         3'd2: nx = m & imm;
         3'd3: nx = m | imm;
         3'd4: nx = m ^ imm;
         default: begin
            if (upd) begin
               if (en[4]) nx[5] = h;
               if (en[3]) nx[3] = n;
               if (en[2]) nx[2] = z;
               if (en[1]) nx[1] = v;
               if (en[0]) nx[0] = c;
            end
         end
      endcase
      if (exc) nx[7] = 1'b1;
      m = nx;
      it.exp = nx;
      it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic sw(input logic [2:0] op, input logic [7:0] imm, input string tag);
      drive(op, imm, 1'b0, 5'd0, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, tag);
   endtask

   task automatic ar(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] b,
                     input bit sub, input logic [4:0] en, input string tag);
      drive(3'd0, 8'h00, 1'b1, en, sz, a, b, sub, 1'b0, tag);
   endtask

   initial begin
      #(4 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; exc_entry = 0; sw_op = 0; sw_imm = 0; arith_upd = 0;
      flag_en = 0; op_size = 0; alu_result = 0; alu_cout = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m = 8'h80;
      #1;
      check(ccr_q, 8'h80, "R1 reset value");
      check({7'd0, irq_masked}, 8'h01, "R1 reset mask");

      // software operations (R8)
      sw(3'd1, 8'h00, "R8 load zero");
      sw(3'd1, 8'h55, "R8 load 55");
      sw(3'd2, 8'h0F, "R8 and");
      sw(3'd3, 8'hA0, "R8 or");
      sw(3'd4, 8'hFF, "R8 xor");
      sw(3'd6, 8'h12, "R8 reserved code holds");
      sw(3'd0, 8'hFF, "R7 idle holds");
      sw(3'd1, 8'h00, "R8 clear");

      // byte arithmetic (R3 R4 R5 R6)
      ar(2'd0, 32'h0000_000F, 32'h0000_0001, 1'b0, 5'h1F, "R3 byte half carry");
      ar(2'd0, 32'h0000_007F, 32'h0000_0001, 1'b0, 5'h1F, "R6 byte overflow R4");
      ar(2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, 5'h1F, "R5 byte zero R6 carry");
      ar(2'd0, 32'h1234_5600, 32'h0000_0000, 1'b0, 5'h1F, "R5 byte upper ignored");
      ar(2'd0, 32'h0000_0010, 32'h0000_0001, 1'b1, 5'h1F, "R3 byte half borrow");
      // word
      ar(2'd1, 32'h0000_0FFF, 32'h0000_0001, 1'b0, 5'h1F, "R3 word half carry");
      ar(2'd1, 32'h0000_000F, 32'h0000_0001, 1'b0, 5'h1F, "R3 word bit3 ignored");
      ar(2'd1, 32'h0000_8000, 32'h0000_0001, 1'b1, 5'h1F, "R6 word overflow sub");
      ar(2'd1, 32'h0001_FFFF, 32'h0000_0001, 1'b0, 5'h1F, "R5 word zero R6");
      // long and reserved size
      ar(2'd2, 32'h0FFF_FFFF, 32'h0000_0001, 1'b0, 5'h1F, "R3 long half carry");
      ar(2'd2, 32'h0000_0000, 32'h0000_0001, 1'b1, 5'h1F, "R6 long borrow R4");
      ar(2'd3, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 5'h1F, "R3 reserved size long");
      ar(2'd2, 32'h8000_0000, 32'h8000_0000, 1'b0, 5'h1F, "R6 long carry zero R5");

      // partial enables (R7) and user bits untouched (R9)
      sw(3'd1, 8'h50, "R8 set user bits");
      ar(2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, 5'b00100, "R7 only zero");
      ar(2'd0, 32'h0000_000F, 32'h0000_0001, 1'b0, 5'b10001, "R7 half and carry R9");
      ar(2'd0, 32'h0000_0080, 32'h0000_0000, 1'b0, 5'b00000, "R7 none enabled");

      // collisions (R10 R11)
      drive(3'd0, 8'h00, 1'b0, 5'd0, 2'd0, 0, 0, 1'b0, 1'b1, "R10 exception alone");
      sw(3'd1, 8'h00, "R8 clear mask");
      drive(3'd1, 8'h03, 1'b0, 5'd0, 2'd0, 0, 0, 1'b0, 1'b1, "R10 exception with load");
      drive(3'd1, 8'h00, 1'b1, 5'h1F, 2'd0, 32'hFF, 32'h01, 1'b0, 1'b0, "R11 sw over arith");
      drive(3'd4, 8'h21, 1'b1, 5'h1F, 2'd0, 32'h0F, 32'h01, 1'b0, 1'b1, "R11 R10 xor triple");

      // mixed random traffic
      for (int i = 0; i < 80; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         drive(rv[2:0] > 3'd4 ? 3'd0 : (rv[3] ? rv[2:0] : 3'd0), rv[15:8], rv[4],
               rv[20:16], rv[22:21], $urandom, $urandom, rv[23], (rv[26:24] == 3'd0),
               "R7 R9 mixed");
      end

      repeat (3) @(posedge clk);
      #1;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule